// File: doc/BRIEF.md
# I2C Slave Byte Engine with Control Register

This block is the slave side of a two-wire serial bus interface, together with a small register file on a synchronous register bus. Software uses the control register to turn the bus engine on and off, to allow an interrupt, and to choose whether received bytes are acknowledged. The engine brings SCL and SDA into the clock domain and detects START and STOP. It compares the first byte after a START with a fixed seven-bit slave address. On a match it acknowledges. It then either shifts bytes in from the bus into the data register or shifts the data register out onto the bus, depending on the direction bit that closes the address byte. After the ninth clock of every byte it takes part in, it raises a status flag. The interrupt output is high while that flag and the interrupt enable are both set.

When the enable bit is low, the whole bus engine and its status are held in reset. The registers remain fully readable and writable. If the engine is enabled while a transfer is already on the bus, it does not join that transfer. It acts only from the next START onward. The master/slave, repeated-start and stop-in-wait bits are stored and read back but drive no logic.

The engine has nine states. `ST_OFF` is held while the enable bit is low and moves to `ST_IDLE` once the enable bit is set. `ST_IDLE` waits for a START, which moves it to `ST_ADDR`. `ST_ADDR` shifts eight bits in. On the eighth falling SCL edge it goes to `ST_ADDR_ACK` if the address matches, or to `ST_SKIP` if it does not. `ST_ADDR_ACK` holds SDA low for the ninth clock. At the end of that clock it goes to `ST_TX` for a read and loads the data register into the shifter, or to `ST_RX` for a write. `ST_RX` shifts a byte in and moves to `ST_RX_ACK`, writing the byte to the data register on the way. `ST_RX_ACK` returns to `ST_RX` after the ninth clock. `ST_TX` shifts a byte out and moves to `ST_TX_ACK`. `ST_TX_ACK` samples the master's acknowledge. An ACK reloads the shifter and returns to `ST_TX`; a NACK goes to `ST_SKIP`. `ST_SKIP` leaves the bus alone. From any state other than `ST_OFF`, a START goes to `ST_ADDR` and a STOP goes to `ST_IDLE`. Clearing the enable bit forces `ST_OFF` from any state.

Top module: `i2c_slave_ctl`

## Requirements
- R1: The register map is: offset 0 is control, offset 1 is status, offset 2 is data; other offsets read 0. Control bits are: 7 enable, 6 interrupt enable, 5 master/slave (stored only), 4 transmit/receive (stored only), 3 no-acknowledge, 2 repeated start (stored only), 0 stop-in-wait (stored only). Bit 1 always reads 0. Control and status read 0 after reset.
- R2: The control and data registers can be written and read back whatever the value of the enable bit.
- R3: While enable is 0, the engine is in reset. SDA is never pulled low, and the status register (bit 6 addressed, bit 2 read request, bit 1 flag) reads 0. Clearing enable during a transfer releases SDA within a few clock cycles.
- R4: While enable is 0, no other control bit affects the bus. No address is acknowledged, and the flag and the interrupt output stay 0.
- R5: If enable is set in the middle of a transfer, the slave neither acknowledges nor flags that transfer. It responds from the next START onward.
- R6: The interrupt output is 1 exactly when the interrupt enable bit and the status flag are both 1.
- R7: Clearing the interrupt enable bit leaves a set status flag set and readable.
- R8: The status flag sets at the falling SCL edge that ends the ninth clock of every acknowledged address byte and of every data byte that follows it. Writing 1 to status bit 1 clears the flag; writing 0 there has no effect.
- R9: When the upper seven bits of the first byte after a START equal `SLAVE_ADDR`, the slave pulls SDA low on the ninth clock. Otherwise it leaves SDA released and ignores the bus until the next START or STOP.
- R10: In a write (address bit 0 = 0), each received byte is placed in the data register. It is acknowledged (SDA low on the ninth clock) when control bit 3 is 0 and not acknowledged when control bit 3 is 1.
- R11: In a read (address bit 0 = 1), the slave sends the data register MSB first. The next byte is taken from the data register at the end of each ninth clock on which the master acknowledged. After a master NACK, SDA stays released.
- R12: A STOP, or a START that arrives in the middle of a byte, returns the engine to waiting for an address. A new address byte is then matched normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on `reg_addr`) |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| sda_pull_low | output | 1 | Pulls the open-drain SDA line low when 1 |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with `SLAVE_ADDR` = 0x3A and two synchronizer stages. The bus master it models holds each SCL phase for eight system clocks, which leaves room for the synchronizer delay before SDA changes. Because 0x3A has both ones and zeros, the mismatch case can use a neighbour that differs in a single bit (0x3B). The two-stage chain also makes the enable-time fill window short enough that a bit boundary can fall just after the enable write, which is where the mid-transfer enable case is placed.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_OFF,
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_SKIP
    } eng_state_t;

    // register offsets
    localparam logic [1:0] OFS_CTRL = 2'd0;
    localparam logic [1:0] OFS_STAT = 2'd1;
    localparam logic [1:0] OFS_DATA = 2'd2;

    // control bit positions
    localparam int CB_EN  = 7;
    localparam int CB_IE  = 6;
    localparam int CB_NAK = 3;
    localparam int CB_RSV = 1;

    // status bit positions
    localparam int SB_HIT  = 6;
    localparam int SB_RD   = 2;
    localparam int SB_FLAG = 1;

endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_lvl,
    output logic ev_start,
    output logic ev_stop,
    output logic ev_rise,
    output logic ev_fall
);
    localparam int FILL_W = STAGES + 1;

    logic [STAGES-1:0] scl_chain, sda_chain;
    logic              scl_q, sda_q;
    logic [FILL_W-1:0] fill;
    logic              valid, scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_chain <= '1;
            sda_chain <= '1;
            scl_q     <= 1'b1;
            sda_q     <= 1'b1;
            fill      <= '0;
        end else if (!en) begin
            scl_chain <= '1;
            sda_chain <= '1;
            scl_q     <= 1'b1;
            sda_q     <= 1'b1;
            fill      <= '0;
        end else begin
            scl_chain[0] <= scl_in;
            sda_chain[0] <= sda_in;
            for (int i = 1; i < STAGES; i++) begin
                scl_chain[i] <= scl_chain[i-1];
                sda_chain[i] <= sda_chain[i-1];
            end
            scl_q <= scl_chain[STAGES-1];
            sda_q <= sda_chain[STAGES-1];
            fill  <= {fill[FILL_W-2:0], 1'b1};
        end
    end

    assign valid    = fill[FILL_W-1];
    assign scl_s    = scl_chain[STAGES-1];
    assign sda_lvl  = sda_chain[STAGES-1];
    assign ev_start = valid && scl_s && scl_q && sda_q && !sda_lvl;
    assign ev_stop  = valid && scl_s && scl_q && !sda_q && sda_lvl;
    assign ev_rise  = valid && scl_s && !scl_q;
    assign ev_fall  = valid && !scl_s && scl_q;

    // no bus event may come out of the first cycle after enabling
    assert_quiet_after_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |=> !(ev_start || ev_stop || ev_rise || ev_fall));

endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
    import i2cs_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR = 7'h3A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              nak_rx,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              sda_lvl,
    input  logic              ev_start,
    input  logic              ev_stop,
    input  logic              ev_rise,
    input  logic              ev_fall,
    output logic              sda_pull,
    output logic              byte_done,
    output logic              rx_wr,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              hit,
    output logic              rd_req
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

    eng_state_t        state;
    logic [BYTE_W-1:0] shreg;
    logic [CNT_W-1:0]  bitcnt;
    logic              ack_seen;
    logic              step;

    assign step = en && !ev_start && !ev_stop;

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_OFF;
            shreg    <= '0;
            bitcnt   <= '0;
            rd_req   <= 1'b0;
            ack_seen <= 1'b0;
        end else if (!en) begin
            state  <= ST_OFF;
            bitcnt <= '0;
            rd_req <= 1'b0;
        end else if (ev_stop) begin
            state <= ST_IDLE;
        end else if (ev_start) begin
            state  <= ST_ADDR;
            bitcnt <= '0;
        end else begin
            unique case (state)
                ST_OFF:  state <= ST_IDLE;
                ST_IDLE: ;
                ST_SKIP: ;
                ST_ADDR, ST_RX: begin
                    if (ev_rise) begin
                        shreg  <= {shreg[BYTE_W-2:0], sda_lvl};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (ev_fall && bitcnt == LAST) begin
                        bitcnt <= '0;
                        if (state == ST_RX) begin
                            state <= ST_RX_ACK;
                        end else if (shreg[BYTE_W-1:1] == SLAVE_ADDR) begin
                            state  <= ST_ADDR_ACK;
                            rd_req <= shreg[0];
                        end else begin
                            state <= ST_SKIP;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (ev_fall) begin
                        if (rd_req) begin
                            state <= ST_TX;
                            shreg <= tx_byte;
                        end else begin
                            state <= ST_RX;
                        end
                    end
                end
                ST_RX_ACK: begin
                    if (ev_fall) state <= ST_RX;
                end
                ST_TX: begin
                    if (ev_rise) begin
                        bitcnt <= bitcnt + 1'b1;
                    end else if (ev_fall) begin
                        if (bitcnt == LAST) begin
                            state  <= ST_TX_ACK;
                            bitcnt <= '0;
                        end else begin
                            shreg <= {shreg[BYTE_W-2:0], 1'b0};
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (ev_rise) begin
                        ack_seen <= !sda_lvl;
                    end else if (ev_fall) begin
                        if (ack_seen) begin
                            state <= ST_TX;
                            shreg <= tx_byte;
                        end else begin
                            state <= ST_SKIP;
                        end
                    end
                end
                default: state <= ST_OFF;
            endcase
        end
    end

    // outputs
    always_comb begin
        sda_pull  = 1'b0;
        byte_done = 1'b0;
        rx_wr     = 1'b0;
        hit       = 1'b0;
        unique case (state)
            ST_ADDR_ACK: begin
                sda_pull  = 1'b1;
                byte_done = step && ev_fall;
                hit       = 1'b1;
            end
            ST_RX: begin
                rx_wr = step && ev_fall && (bitcnt == LAST);
                hit   = 1'b1;
            end
            ST_RX_ACK: begin
                sda_pull  = !nak_rx;
                byte_done = step && ev_fall;
                hit       = 1'b1;
            end
            ST_TX: begin
                sda_pull = !shreg[BYTE_W-1];
                hit      = 1'b1;
            end
            ST_TX_ACK: begin
                byte_done = step && ev_fall;
                hit       = 1'b1;
            end
            default: ;
        endcase
    end

    assign rx_byte = shreg;

    assert_off_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !sda_pull);
    assert_start_addr_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ev_start && !ev_stop) |=> (state == ST_ADDR));
    assert_stop_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ev_stop) |=> (state == ST_IDLE));
    assert_done_leaves_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> (state == ST_RX || state == ST_TX || state == ST_SKIP));

endmodule

// File: rtl/i2cs_regs.sv
module i2cs_regs
    import i2cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic [BYTE_W-1:0] ctrl,
    output logic [BYTE_W-1:0] data,
    input  logic              byte_done,
    input  logic              rx_wr,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              hit,
    input  logic              rd_req,
    output logic              irq
);
    logic flag, clr_req, en;

    assign en      = ctrl[CB_EN];
    assign clr_req = reg_wr && (reg_addr == OFS_STAT) && reg_wdata[SB_FLAG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (reg_wr && reg_addr == OFS_CTRL) begin
            ctrl <= reg_wdata & ~(BYTE_W'(1) << CB_RSV);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data <= '0;
        end else if (rx_wr) begin
            data <= rx_byte;
        end else if (reg_wr && reg_addr == OFS_DATA) begin
            data <= reg_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         flag <= 1'b0;
        else if (!en)       flag <= 1'b0;
        else if (byte_done) flag <= 1'b1;
        else if (clr_req)   flag <= 1'b0;
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_CTRL: reg_rdata = ctrl;
            OFS_STAT: begin
                reg_rdata[SB_HIT]  = hit;
                reg_rdata[SB_RD]   = rd_req;
                reg_rdata[SB_FLAG] = flag;
            end
            OFS_DATA: reg_rdata = data;
            default:  reg_rdata = '0;
        endcase
    end

    assign irq = ctrl[CB_IE] & flag;

    assert_flag_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && en && !clr_req && !(reg_wr && reg_addr == OFS_CTRL && !reg_wdata[CB_EN])) |=> flag);
    assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFS_CTRL) |-> !reg_rdata[CB_RSV]);

endmodule

// File: rtl/i2c_slave_ctl.sv
module i2c_slave_ctl
    import i2cs_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR  = 7'h3A,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] reg_addr,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_pull_low,
    output logic       irq
);
    logic [BYTE_W-1:0] ctrl, data, rx_byte;
    logic sda_lvl, ev_start, ev_stop, ev_rise, ev_fall;
    logic byte_done, rx_wr, hit, rd_req;

    i2cs_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ctrl      (ctrl),
        .data      (data),
        .byte_done (byte_done),
        .rx_wr     (rx_wr),
        .rx_byte   (rx_byte),
        .hit       (hit),
        .rd_req    (rd_req),
        .irq       (irq)
    );

    i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (ctrl[CB_EN]),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .sda_lvl  (sda_lvl),
        .ev_start (ev_start),
        .ev_stop  (ev_stop),
        .ev_rise  (ev_rise),
        .ev_fall  (ev_fall)
    );

    i2cs_engine #(.SLAVE_ADDR(SLAVE_ADDR)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (ctrl[CB_EN]),
        .nak_rx    (ctrl[CB_NAK]),
        .tx_byte   (data),
        .sda_lvl   (sda_lvl),
        .ev_start  (ev_start),
        .ev_stop   (ev_stop),
        .ev_rise   (ev_rise),
        .ev_fall   (ev_fall),
        .sda_pull  (sda_pull_low),
        .byte_done (byte_done),
        .rx_wr     (rx_wr),
        .rx_byte   (rx_byte),
        .hit       (hit),
        .rd_req    (rd_req)
    );

endmodule

// File: tb/i2c_slave_ctl_bench.sv
`timescale 1ns/1ps
module i2c_slave_ctl_bench;
    localparam logic [6:0] ADR = 7'h3A;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [1:0] ra = '0;
    logic       rw = 1'b0;
    logic [7:0] wd = '0;
    logic [7:0] rd;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic       sda_pull, irq;
    wire        sda_bus = sda_m & ~sda_pull;

    i2c_slave_ctl #(.SLAVE_ADDR(ADR), .SYNC_STAGES(2)) u_i2c_slave_ctl (
        .clk(clk), .rst_n(rst_n), .reg_addr(ra), .reg_wr(rw), .reg_wdata(wd),
        .reg_rdata(rd), .scl_in(scl_m), .sda_in(sda_bus),
        .sda_pull_low(sda_pull), .irq(irq)
    );

    int checks = 0, errors = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        ra = a; wd = d; rw = 1'b1;
        @(posedge clk); #1;
        rw = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        @(posedge clk); #1;
        ra = a; #1;
        d = rd;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_clk(Q);
        scl_m = 1'b1; wait_clk(Q);
        sda_m = 1'b0; wait_clk(Q);
        scl_m = 1'b0; wait_clk(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clk(Q);
        scl_m = 1'b1; wait_clk(Q);
        sda_m = 1'b1; wait_clk(Q);
    endtask

    task automatic bus_bit(input logic b, output logic s);
        sda_m = b;    wait_clk(Q);
        scl_m = 1'b1; wait_clk(Q);
        s = sda_bus;  wait_clk(Q);
        scl_m = 1'b0; wait_clk(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int from, input int downto);
        logic s;
        for (int i = from; i >= downto; i--) bus_bit(b[i], s);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 7, 0);
        bus_bit(1'b1, ack);
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) bus_bit(1'b1, b[i]);
        bus_bit(mack, s);
    endtask

    // expected values from the requirements
    function automatic logic exp_addr_ack(input logic [6:0] a);
        return (a == ADR) ? 1'b0 : 1'b1;
    endfunction
    function automatic logic exp_rx_ack(input logic nak);
        return nak;
    endfunction
    function automatic logic [7:0] exp_stat(input logic hit, input logic rdq, input logic flg);
        return {1'b0, hit, 3'b000, rdq, flg, 1'b0};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic       ack;
        logic [7:0] d;
        logic       nak;
        logic       dir;
        logic [6:0] a;
        void'($urandom(32'h1C2B));

        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);

        // R1 reset state
        reg_read(2'd0, v); check("R1 ctrl reset", v, 8'h00);
        reg_read(2'd1, v); check("R1 status reset", v, 8'h00);
        reg_read(2'd3, v); check("R1 unused offset", v, 8'h00);
        check("R1 irq reset", irq, 1'b0);
        check("R1 sda released", sda_pull, 1'b0);

        // R2 / R1 access while disabled, reserved bit
        reg_write(2'd0, 8'h7F);
        reg_read(2'd0, v); check("R2 ctrl rw while disabled, R1 bit1 zero", v, 8'h7D);
        reg_write(2'd2, 8'hC3);
        reg_read(2'd2, v); check("R2 data rw while disabled", v, 8'hC3);

        // R4 no effect while disabled
        bus_start();
        send_byte({ADR, 1'b0}, ack);
        check("R4 no ack while disabled", ack, 1'b1);
        check("R4 irq stays low", irq, 1'b0);
        reg_read(2'd1, v); check("R4 status stays zero", v, 8'h00);
        bus_stop();

        // R5 enable in mid-transfer
        reg_write(2'd0, 8'h00);
        bus_start();
        send_bits({ADR, 1'b0}, 7, 5);
        reg_write(2'd0, 8'h80);
        send_bits({ADR, 1'b0}, 4, 0);
        bus_bit(1'b1, ack);
        check("R5 mid-transfer not acked", ack, 1'b1);
        reg_read(2'd1, v); check("R5 mid-transfer not flagged", v, 8'h00);
        bus_stop();

        // R9 / R8 matched write address
        bus_start();
        send_byte({ADR, 1'b0}, ack);
        check("R9 address acked", ack, exp_addr_ack(ADR));
        reg_read(2'd1, v); check("R8 flag after address byte", v, exp_stat(1'b1, 1'b0, 1'b1));
        check("R6 irq low with ie clear", irq, 1'b0);
        reg_write(2'd0, 8'hC0);
        wait_clk(1);
        check("R6 irq high with ie and flag", irq, 1'b1);
        reg_write(2'd0, 8'h80);
        wait_clk(1);
        check("R6 irq low after ie cleared", irq, 1'b0);
        reg_read(2'd1, v); check("R7 flag kept after ie cleared", v[1], 1'b1);
        reg_write(2'd1, 8'h00);
        reg_read(2'd1, v); check("R8 write 0 keeps flag", v[1], 1'b1);
        reg_write(2'd1, 8'h02);
        reg_read(2'd1, v); check("R8 write 1 clears flag", v[1], 1'b0);

        // R10 receive with and without ack
        send_byte(8'hA5, ack);
        check("R10 rx byte acked", ack, exp_rx_ack(1'b0));
        reg_read(2'd2, v); check("R10 rx data stored", v, 8'hA5);
        reg_read(2'd1, v); check("R8 flag after data byte", v[1], 1'b1);
        reg_write(2'd1, 8'h02);
        reg_write(2'd0, 8'h88);
        send_byte(8'h3C, ack);
        check("R10 rx byte nacked", ack, exp_rx_ack(1'b1));
        reg_read(2'd2, v); check("R10 nacked data stored", v, 8'h3C);
        bus_stop();
        wait_clk(4);
        reg_read(2'd1, v); check("R12 stop leaves addressed state", v[6], 1'b0);
        reg_write(2'd1, 8'h02);

        // R9 mismatch
        reg_write(2'd0, 8'h80);
        bus_start();
        send_byte({ADR ^ 7'h01, 1'b0}, ack);
        check("R9 mismatch not acked", ack, exp_addr_ack(ADR ^ 7'h01));
        send_byte(8'h00, ack);
        check("R9 following byte ignored", ack, 1'b1);
        reg_read(2'd2, v); check("R9 data untouched", v, 8'h3C);
        reg_read(2'd1, v); check("R9 no flag", v, 8'h00);
        bus_stop();

        // R11 transmit
        reg_write(2'd2, 8'h96);
        bus_start();
        send_byte({ADR, 1'b1}, ack);
        check("R11 read address acked", ack, 1'b0);
        reg_read(2'd1, v); check("R11 read request status", v, exp_stat(1'b1, 1'b1, 1'b1));
        reg_write(2'd1, 8'h02);
        reg_write(2'd2, 8'h5B);
        recv_byte(1'b0, v); check("R11 first byte", v, 8'h96);
        recv_byte(1'b1, v); check("R11 second byte", v, 8'h5B);
        recv_byte(1'b1, v); check("R11 released after nack", v, 8'hFF);
        bus_stop();
        reg_write(2'd1, 8'h02);

        // R12 stop and start in the middle of a byte
        bus_start();
        send_byte({ADR, 1'b0}, ack);
        send_bits(8'h00, 7, 5);
        bus_stop();
        bus_start();
        send_byte({ADR, 1'b0}, ack);
        check("R12 address after mid-byte stop", ack, 1'b0);
        send_bits(8'hFF, 7, 4);
        bus_start();
        send_byte({ADR, 1'b0}, ack);
        check("R12 address after mid-byte start", ack, 1'b0);
        bus_stop();
        reg_write(2'd1, 8'h02);

        // R3 disable during transmit
        reg_write(2'd2, 8'h00);
        bus_start();
        send_byte({ADR, 1'b1}, ack);
        send_bits(8'hFF, 7, 5);
        check("R3 slave driving before disable", sda_pull, 1'b1);
        reg_write(2'd0, 8'h40);
        wait_clk(3);
        check("R3 sda released after disable", sda_pull, 1'b0);
        reg_read(2'd1, v); check("R3 status cleared", v, 8'h00);
        check("R3 irq low", irq, 1'b0);
        reg_read(2'd0, v); check("R2 ctrl readable after disable", v, 8'h40);
        bus_stop();

        // random transfers
        for (int it = 0; it < 10; it++) begin
            d   = 8'($urandom);
            nak = 1'($urandom);
            dir = 1'($urandom);
            a   = ($urandom % 4 == 0) ? 7'($urandom) : ADR;
            reg_write(2'd0, {4'h8, nak, 3'b000});
            if (dir) reg_write(2'd2, d);
            bus_start();
            send_byte({a, dir}, ack);
            check("R9 random address", ack, exp_addr_ack(a));
            if (a == ADR) begin
                if (dir) begin
                    recv_byte(1'b1, v);
                    check("R11 random tx byte", v, d);
                end else begin
                    send_byte(d, ack);
                    check("R10 random rx ack", ack, exp_rx_ack(nak));
                    reg_read(2'd2, v); check("R10 random rx data", v, d);
                end
                reg_read(2'd1, v); check("R8 random flag", v[1], 1'b1);
            end
            bus_stop();
            reg_write(2'd1, 8'h02);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule